// File: doc/BRIEF.md
# BCD Calendar Clock Core

This core keeps calendar time as eight BCD registers: hundredths of seconds, seconds, minutes, hours, day of week, date, month and year. It advances by one hundredth on each cycle in which the 100 Hz tick enable is high, and it carries through the whole chain in that same cycle. Month lengths come from the month and year, and February gains a 29th day in leap years. Hours count in either 24-hour or 12-hour form. The 12-hour form has an AM/PM flag.

A host path outside this core sees all eight registers as one 64-bit snapshot, and can load them as one 64-bit word. Register k sits at bits [8k+7:8k]. Two control bits live in the day register. One stops the timebase. The other decides whether an external active-low reset may abort a host register transfer. The core reports that abort on a registered output and never alters the time because of it.

Top module: `bcd_rtc_core`

## Requirements
- R1: After synchronous reset the snapshot is 64'h0001_0131_0000_0000: year 00, month 01, date 01, day register 8'h31 (timebase stopped, reset-ignore set, day 1), and zero in hours, minutes, seconds and hundredths. `xfer_abort` is 0.
- R2: Register 0 (hundredths) counts 00 to 99 in BCD on each tick, and at 99 wraps to 00 and carries. Register 1 (seconds, bits 6:0) and register 2 (minutes, bits 6:0) count 00 to 59, wrap and carry in the same way.
- R3: Register 3 (hours) with bit 7 = 0 uses 24-hour form: bits 5:0 count 00 to 23 in BCD, and 23 to 00 carries into date and day of week.
- R4: With hours bit 7 = 1 the form is 12-hour. Bits 4:0 run 12, 01 … 11 and bit 5 is PM. The 11 to 12 step toggles PM, and it carries into the date only when PM was 1 before the step.
- R5: Register 5 (date, bits 5:0) wraps to 01 and carries into the month after its last day. The last day is 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 for all other months.
- R6: February has 29 days when the BCD year in register 7 is divisible by 4, year 00 included.
- R7: Register 4 bits 2:0 (day of week) count 1 to 7 and wrap to 1. Register 6 (month, bits 4:0) wraps from 12 to 01 and carries into register 7 (year), which wraps from 99 to 00.
- R8: While register 4 bit 5 is 1, tick enables change no register.
- R9: Bits that are not used read back as 0 whatever is loaded. These are register 1 bit 7, register 2 bit 7, register 3 bit 6, register 4 bits 7:6 and bit 3, register 5 bits 7:6, and register 6 bits 7:5.
- R10: A load writes all eight registers in one cycle, and the value can be read back on the next cycle. A tick in the load cycle is discarded, so the count starts afresh from the loaded value.
- R11: When register 4 bit 4 is 0 and `ext_rst_n` is low, `xfer_abort` is 1 in the following cycle and the time registers do not change. When register 4 bit 4 is 1, `ext_rst_n` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 100 Hz advance enable, one cycle wide |
| load_en | input | 1 | Load all registers from `load_data` |
| load_data | input | 64 | Register image, register k at bits [8k+7:8k] |
| ext_rst_n | input | 1 | External active-low transfer reset |
| snapshot | output | 64 | Registered image of all eight registers |
| xfer_abort | output | 1 | Registered request to abort a host transfer |

## Verification
Every result appears one clock edge after its stimulus. A load is visible after the edge that takes it. A tick, with its whole carry chain up to the year, is visible after the edge that takes it. `xfer_abort` follows `ext_rst_n` by one edge. Each scenario drives the load on one falling edge, drives the tick on the next falling edge, and compares the snapshot on the falling edge after that. No sample is therefore taken at an active edge, and none is taken a cycle early or late.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int SNAP_W   = REG_W * NUM_REGS;

  // Writable bits per register; unused positions are cleared on load.
  localparam logic [SNAP_W-1:0] KEEP_MASK = 64'hFF1F_3F37_BF7F_7FFF;

  function automatic logic [REG_W-1:0] bcd_next(input logic [REG_W-1:0] v);
    if (v[3:0] == 4'd9) bcd_next = {v[7:4] + 4'd1, 4'd0};
    else                bcd_next = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [REG_W-1:0] yr);
    if (yr[4]) is_leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       is_leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction
endpackage

// File: rtl/rtc_bcd_cnt.sv
module rtc_bcd_cnt
  import rtc_pkg::*;
#(
  parameter logic [REG_W-1:0] LO = 8'h00,
  parameter logic [REG_W-1:0] HI = 8'h99
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REG_W-1:0] load_val,
  input  logic             inc,
  output logic [REG_W-1:0] val,
  output logic             wrap
);
  assign wrap = inc && (val == HI);

  always_ff @(posedge clk) begin
    if (rst)       val <= LO;
    else if (load) val <= load_val;
    else if (inc)  val <= (val == HI) ? LO : bcd_next(val);
  end

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && val == HI) |=> (val == LO));
endmodule

// File: rtl/rtc_hour_cnt.sv
module rtc_hour_cnt
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REG_W-1:0] load_val,
  input  logic             inc,
  output logic [REG_W-1:0] hval,
  output logic             day_carry
);
  logic [REG_W-1:0] nxt;
  logic             carry;

  always_comb begin
    nxt   = hval;
    carry = 1'b0;
    if (hval[7]) begin
      if (hval[4:0] == 5'h12) nxt[4:0] = 5'h01;
      else if (hval[4:0] == 5'h11) begin
        nxt[4:0] = 5'h12;
        nxt[5]   = ~hval[5];
        carry    = hval[5];
      end else if (hval[3:0] == 4'd9) nxt[4:0] = 5'h10;
      else nxt[3:0] = hval[3:0] + 4'd1;
    end else begin
      if (hval[5:0] == 6'h23) begin
        nxt[5:0] = 6'h00;
        carry    = 1'b1;
      end else if (hval[3:0] == 4'd9) nxt[5:0] = {hval[5:4] + 2'd1, 4'd0};
      else nxt[3:0] = hval[3:0] + 4'd1;
    end
  end

  assign day_carry = inc && carry;

  always_ff @(posedge clk) begin
    if (rst)       hval <= '0;
    else if (load) hval <= load_val;
    else if (inc)  hval <= nxt;
  end

  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && hval[7] && hval[4:0] == 5'h11) |=> (hval[5] != $past(hval[5])));
  // R3
  h24_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && !hval[7] && hval[5:0] == 6'h23) |=> (hval[5:0] == 6'h00));
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [REG_W-1:0] month,
  input  logic [REG_W-1:0] year,
  output logic [REG_W-1:0] last_date
);
  always_comb begin
    case (month[4:0])
      5'h02:                      last_date = is_leap(year) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              load_en,
  input  logic [SNAP_W-1:0] load_data,
  input  logic              ext_rst_n,
  output logic [SNAP_W-1:0] snapshot,
  output logic              xfer_abort
);
  localparam logic [REG_W-1:0] DAY_RST = 8'h31;

  logic [SNAP_W-1:0] ld;
  logic [REG_W-1:0]  hund, sec, mins, hour, day_r, date_r, mon_r, year;
  logic [REG_W-1:0]  last_date;
  logic              run, c_sec, c_min, c_hour, c_day, c_mon, c_year, unused_w;

  assign ld  = load_data & KEEP_MASK;
  assign run = tick_en && !load_en && !day_r[5];

  rtc_bcd_cnt #(.LO(8'h00), .HI(8'h99)) u_hund (
    .clk(clk), .rst(rst), .load(load_en), .load_val(ld[7:0]),
    .inc(run), .val(hund), .wrap(c_sec));
  rtc_bcd_cnt #(.LO(8'h00), .HI(8'h59)) u_sec (
    .clk(clk), .rst(rst), .load(load_en), .load_val(ld[15:8]),
    .inc(c_sec), .val(sec), .wrap(c_min));
  rtc_bcd_cnt #(.LO(8'h00), .HI(8'h59)) u_min (
    .clk(clk), .rst(rst), .load(load_en), .load_val(ld[23:16]),
    .inc(c_min), .val(mins), .wrap(c_hour));
  rtc_hour_cnt u_hour (
    .clk(clk), .rst(rst), .load(load_en), .load_val(ld[31:24]),
    .inc(c_hour), .hval(hour), .day_carry(c_day));
  rtc_month_len u_mlen (.month(mon_r), .year(year), .last_date(last_date));
  rtc_bcd_cnt #(.LO(8'h00), .HI(8'h99)) u_year (
    .clk(clk), .rst(rst), .load(load_en), .load_val(ld[63:56]),
    .inc(c_year), .val(year), .wrap(unused_w));

  assign c_mon  = c_day && (date_r == last_date);
  assign c_year = c_mon && (mon_r == 8'h12);

  always_ff @(posedge clk) begin
    if (rst) begin
      day_r  <= DAY_RST;
      date_r <= 8'h01;
      mon_r  <= 8'h01;
    end else if (load_en) begin
      day_r  <= ld[39:32];
      date_r <= ld[47:40];
      mon_r  <= ld[55:48];
    end else begin
      if (c_day) begin
        day_r[2:0] <= (day_r[2:0] == 3'd7) ? 3'd1 : day_r[2:0] + 3'd1;
        date_r     <= (date_r == last_date) ? 8'h01 : bcd_next(date_r);
      end
      if (c_mon) mon_r <= (mon_r == 8'h12) ? 8'h01 : bcd_next(mon_r);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) xfer_abort <= 1'b0;
    else     xfer_abort <= !day_r[4] && !ext_rst_n;
  end

  assign snapshot = {year, mon_r, date_r, day_r, hour, mins, sec, hund};

  // R8
  osc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && snapshot[37]) |=> $stable(snapshot));
  // R10
  load_img_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (snapshot == $past(load_data & KEEP_MASK)));
  // R11
  abort_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_rst_n && !snapshot[36]) |=> xfer_abort);
endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        load_en = 1'b0;
  logic [63:0] load_data = '0;
  logic        ext_rst_n = 1'b1;
  logic [63:0] snapshot;
  logic        xfer_abort;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bcd_rtc_core dut (.clk(clk), .rst(rst), .tick_en(tick_en), .load_en(load_en),
    .load_data(load_data), .ext_rst_n(ext_rst_n), .snapshot(snapshot),
    .xfer_abort(xfer_abort));

  function automatic logic [63:0] mk(input logic [7:0] yr, mo, dt, dy, hr, mi, se, hu);
    return {yr, mo, dt, dy, hr, mi, se, hu};
  endfunction

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] v, input logic tk);
    @(negedge clk); load_en = 1'b1; load_data = v; tick_en = tk;
    @(negedge clk); load_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic do_tick;
    tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic step_case(input string req, input logic [63:0] v, input logic [63:0] exp);
    do_load(v, 1'b0);
    do_tick();
    chk64(req, snapshot, exp);
  endtask

  task automatic t_reset;
    chk64("R1 reset image", snapshot, 64'h0001_0131_0000_0000);
    chk64("R1 abort idle", {63'd0, xfer_abort}, 64'd0);
    do_tick();
    chk64("R8 stopped after reset", snapshot, 64'h0001_0131_0000_0000);
  endtask

  task automatic t_zero_bits;
    do_load({64{1'b1}}, 1'b0);
    chk64("R9 unused bits", snapshot, 64'hFF1F_3F37_BF7F_7FFF);
  endtask

  task automatic t_count;
    step_case("R2 hundredths digit", mk(8'h10,8'h03,8'h05,8'h12,8'h08,8'h00,8'h00,8'h09),
                                     mk(8'h10,8'h03,8'h05,8'h12,8'h08,8'h00,8'h00,8'h10));
    step_case("R2 sec/min carry",    mk(8'h10,8'h03,8'h05,8'h12,8'h08,8'h09,8'h59,8'h99),
                                     mk(8'h10,8'h03,8'h05,8'h12,8'h08,8'h10,8'h00,8'h00));
  endtask

  task automatic t_24h;
    step_case("R3 hour 19 to 20",    mk(8'h10,8'h03,8'h05,8'h12,8'h19,8'h59,8'h59,8'h99),
                                     mk(8'h10,8'h03,8'h05,8'h12,8'h20,8'h00,8'h00,8'h00));
    step_case("R3 R7 full rollover", mk(8'h99,8'h12,8'h31,8'h17,8'h23,8'h59,8'h59,8'h99),
                                     mk(8'h00,8'h01,8'h01,8'h11,8'h00,8'h00,8'h00,8'h00));
  endtask

  task automatic t_month;
    step_case("R5 April end",        mk(8'h23,8'h04,8'h30,8'h13,8'h23,8'h59,8'h59,8'h99),
                                     mk(8'h23,8'h05,8'h01,8'h14,8'h00,8'h00,8'h00,8'h00));
    step_case("R5 January end",      mk(8'h23,8'h01,8'h31,8'h12,8'h23,8'h59,8'h59,8'h99),
                                     mk(8'h23,8'h02,8'h01,8'h13,8'h00,8'h00,8'h00,8'h00));
    step_case("R5 mid-month",        mk(8'h23,8'h06,8'h29,8'h12,8'h23,8'h59,8'h59,8'h99),
                                     mk(8'h23,8'h06,8'h30,8'h13,8'h00,8'h00,8'h00,8'h00));
  endtask

  task automatic t_leap;
    step_case("R6 leap Feb 28",      mk(8'h24,8'h02,8'h28,8'h12,8'h23,8'h59,8'h59,8'h99),
                                     mk(8'h24,8'h02,8'h29,8'h13,8'h00,8'h00,8'h00,8'h00));
    step_case("R6 leap Feb 29",      mk(8'h24,8'h02,8'h29,8'h12,8'h23,8'h59,8'h59,8'h99),
                                     mk(8'h24,8'h03,8'h01,8'h13,8'h00,8'h00,8'h00,8'h00));
    step_case("R6 common Feb 28",    mk(8'h23,8'h02,8'h28,8'h12,8'h23,8'h59,8'h59,8'h99),
                                     mk(8'h23,8'h03,8'h01,8'h13,8'h00,8'h00,8'h00,8'h00));
    step_case("R6 year 00 leap",     mk(8'h00,8'h02,8'h28,8'h12,8'h23,8'h59,8'h59,8'h99),
                                     mk(8'h00,8'h02,8'h29,8'h13,8'h00,8'h00,8'h00,8'h00));
  endtask

  task automatic t_12h;
    step_case("R4 AM 11 to PM 12",   mk(8'h05,8'h06,8'h15,8'h13,8'h91,8'h59,8'h59,8'h99),
                                     mk(8'h05,8'h06,8'h15,8'h13,8'hB2,8'h00,8'h00,8'h00));
    step_case("R4 PM 11 to AM 12",   mk(8'h05,8'h06,8'h15,8'h13,8'hB1,8'h59,8'h59,8'h99),
                                     mk(8'h05,8'h06,8'h16,8'h14,8'h92,8'h00,8'h00,8'h00));
    step_case("R4 12 to 01",         mk(8'h05,8'h06,8'h15,8'h13,8'hB2,8'h59,8'h59,8'h99),
                                     mk(8'h05,8'h06,8'h15,8'h13,8'hA1,8'h00,8'h00,8'h00));
    step_case("R4 09 to 10",         mk(8'h05,8'h06,8'h15,8'h13,8'h89,8'h59,8'h59,8'h99),
                                     mk(8'h05,8'h06,8'h15,8'h13,8'h90,8'h00,8'h00,8'h00));
  endtask

  task automatic t_day_wrap;
    step_case("R7 weekday 7 to 1",   mk(8'h42,8'h07,8'h10,8'h07,8'h23,8'h59,8'h59,8'h99),
                                     mk(8'h42,8'h07,8'h11,8'h01,8'h00,8'h00,8'h00,8'h00));
  endtask

  task automatic t_osc_stop;
    step_case("R8 stopped no count", mk(8'h05,8'h06,8'h15,8'h33,8'h10,8'h59,8'h59,8'h99),
                                     mk(8'h05,8'h06,8'h15,8'h33,8'h10,8'h59,8'h59,8'h99));
  endtask

  task automatic t_load_prio;
    do_load(mk(8'h07,8'h08,8'h09,8'h12,8'h11,8'h22,8'h33,8'h99), 1'b1);
    chk64("R10 load beats tick", snapshot, mk(8'h07,8'h08,8'h09,8'h12,8'h11,8'h22,8'h33,8'h99));
    do_tick();
    chk64("R10 count from load", snapshot, mk(8'h07,8'h08,8'h09,8'h12,8'h11,8'h22,8'h34,8'h00));
  endtask

  task automatic t_abort;
    do_load(mk(8'h07,8'h08,8'h09,8'h02,8'h11,8'h22,8'h33,8'h44), 1'b0);
    ext_rst_n = 1'b0;
    @(negedge clk); ext_rst_n = 1'b1;
    chk64("R11 abort raised", {63'd0, xfer_abort}, 64'd1);
    chk64("R11 time kept", snapshot, mk(8'h07,8'h08,8'h09,8'h02,8'h11,8'h22,8'h33,8'h44));
    @(negedge clk);
    chk64("R11 abort cleared", {63'd0, xfer_abort}, 64'd0);
    do_load(mk(8'h07,8'h08,8'h09,8'h12,8'h11,8'h22,8'h33,8'h44), 1'b0);
    ext_rst_n = 1'b0;
    @(negedge clk); ext_rst_n = 1'b1;
    chk64("R11 input ignored", {63'd0, xfer_abort}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_bits();
    t_count();
    t_24h();
    t_month();
    t_leap();
    t_12h();
    t_day_wrap();
    t_osc_stop();
    t_load_prio();
    t_abort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule